// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates virtual addresses to physical addresses through a fully associative table of 48 entries (a parameter). Each entry maps two adjacent virtual pages, an even one and an odd one, that share one virtual tag. Each half of the entry carries its own frame number, valid flag and dirty flag. The page size is chosen per entry by a small size code. A tag is the part of the address above the page pair, up to and including the two region bits at the top of the address. A tag comparison succeeds when the address space identifier matches or when the entry is marked global.

Software-side logic fills the table through a write port that loads every field of one entry at a given index. A lookup port takes a virtual address, the current address space identifier and a write flag. One cycle later it returns one of two results. The first is a hit, with the physical address and a read-only or read/write indication. The second is a fault, which is a refill miss, an invalid page or a modify violation. On every fault the block also returns the faulting virtual tag and identifier, which are ready to be written into the fault context registers.

Top module: `pair_tlb`

## Requirements
- R1: While reset is applied, and until the first lookup afterwards, every response output is zero. Reset clears every field of every entry.
- R2: A lookup strobed on `lk_req` at a rising edge produces `rsp_valid` high, with its result, right after the next rising edge. In a cycle that follows no strobe, every response output is zero.
- R3: Size code s (0 to 6) gives a page shift of 12+2s bits, so code 0 is a 4 KB page. A code above 6 is stored as 6. An entry's tag is virtual address bits [39:13]. The comparison ignores the lowest 2s bits of the tag, which keeps the two region bits [39:38].
- R4: Virtual address bit number (12+2s) selects the odd half of the entry when it is 1 and the even half when it is 0.
- R5: An entry matches when the tags agree and either the entry's identifier equals `lk_asid` or the entry's global flag is set.
- R6: On a hit, `rsp_pa` equals the selected frame number shifted left by 12, ORed with virtual address bits [12+2s-1:0].
- R7: On a hit, `rsp_rw` is 1 when the selected half is dirty and 0 (read-only) otherwise. `rsp_code` is 0 and `rsp_refill` is 0.
- R8: A match whose selected half is not valid gives `rsp_code` 2 for a read and 3 for a write, with `rsp_refill` 0 and no hit.
- R9: A write that matches a valid, non-dirty half gives `rsp_code` 1 (modify) and no hit.
- R10: When no entry matches, `rsp_refill` is 1 and `rsp_code` is 2 for a read and 3 for a write.
- R11: On any fault, `rsp_ctx_vpn2` carries virtual address bits [39:13] and `rsp_ctx_asid` carries the lookup's identifier. On a hit, both are zero.
- R12: A write with `wr_en` high loads all fields into the entry at `wr_idx` at that edge, and replaces the previous mapping there.
- R13: When several entries match, the one with the lowest index determines the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one entry this cycle |
| wr_idx | input | 6 | Entry index to load |
| wr_size | input | 3 | Page size code |
| wr_vpn2 | input | 27 | Virtual tag, address bits [39:13] |
| wr_asid | input | 8 | Address space identifier of the entry |
| wr_glob | input | 1 | Entry matches any identifier |
| wr_pfn_even | input | 24 | Frame number of the even page |
| wr_v_even | input | 1 | Even page valid |
| wr_d_even | input | 1 | Even page dirty (writable) |
| wr_pfn_odd | input | 24 | Frame number of the odd page |
| wr_v_odd | input | 1 | Odd page valid |
| wr_d_odd | input | 1 | Odd page dirty (writable) |
| lk_req | input | 1 | Lookup strobe |
| lk_va | input | 40 | Virtual address to translate |
| lk_asid | input | 8 | Current address space identifier |
| lk_write | input | 1 | Lookup is for a store |
| rsp_valid | output | 1 | Result of the previous cycle's lookup |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_rw | output | 1 | Hit page is read/write (0: read-only) |
| rsp_pa | output | 36 | Physical address on a hit |
| rsp_code | output | 2 | Fault code: 0 none, 1 modify, 2 load, 3 store |
| rsp_refill | output | 1 | Fault is a refill miss |
| rsp_ctx_vpn2 | output | 27 | Faulting virtual tag |
| rsp_ctx_asid | output | 8 | Faulting identifier |

## Verification
A corrupted entry field shows up on the first lookup that reaches that entry, one cycle after the strobe. A bad frame number shows as a wrong physical address. A bad tag, identifier or global flag turns a hit into a refill, or a refill into a hit. A bad valid or dirty flag changes the fault code or the read/write indication. A wrong size code moves the odd/even select bit, the tag comparison and the offset mask together, so the bench uses several sizes with offsets that cross each boundary. It compares the whole response against its own model on every clock, so any wrong state is reported within one cycle of the lookup that exposes it.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int MIN_SHIFT = 12;
  localparam int MAX_SIZE  = 6;
  localparam int SIZE_W    = 3;

  typedef enum logic [1:0] {
    CODE_NONE  = 2'd0,
    CODE_MOD   = 2'd1,
    CODE_LOAD  = 2'd2,
    CODE_STORE = 2'd3
  } fault_code_e;
endpackage

// File: rtl/ptlb_store.sv
module ptlb_store import ptlb_pkg::*; #(
  parameter int N_ENT  = 48,
  parameter int IDX_W  = 6,
  parameter int VA_W   = 40,
  parameter int VPN2_W = 27,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 24
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [SIZE_W-1:0]              wr_size,
  input  logic [VPN2_W-1:0]              wr_vpn2,
  input  logic [ASID_W-1:0]              wr_asid,
  input  logic                           wr_glob,
  input  logic [PFN_W-1:0]               wr_pfn_even,
  input  logic                           wr_v_even,
  input  logic                           wr_d_even,
  input  logic [PFN_W-1:0]               wr_pfn_odd,
  input  logic                           wr_v_odd,
  input  logic                           wr_d_odd,
  input  logic [VA_W-1:0]                lk_va,
  input  logic [ASID_W-1:0]              lk_asid,
  output logic [N_ENT-1:0]               match_vec,
  output logic [N_ENT-1:0][PFN_W-1:0]    half_pfn,
  output logic [N_ENT-1:0]               half_v,
  output logic [N_ENT-1:0]               half_d,
  output logic [N_ENT-1:0][SIZE_W-1:0]   half_sz
);
  localparam int SH_W = $clog2(VA_W);

  logic [VPN2_W-1:0] lk_tag;
  assign lk_tag = lk_va[VA_W-1:MIN_SHIFT+1];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic [SIZE_W-1:0] sz_q;
    logic [VPN2_W-1:0] vpn2_q;
    logic [ASID_W-1:0] asid_q;
    logic              glob_q;
    logic [PFN_W-1:0]  pfn0_q, pfn1_q;
    logic              v0_q, d0_q, v1_q, d1_q;
    logic              load_en;
    logic [VPN2_W-1:0] care;
    logic [SH_W-1:0]   shamt;
    logic [VA_W-1:0]   va_sh;
    logic              odd;

    assign load_en = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sz_q   <= '0;
        vpn2_q <= '0;
        asid_q <= '0;
        glob_q <= 1'b0;
        pfn0_q <= '0;
        v0_q   <= 1'b0;
        d0_q   <= 1'b0;
        pfn1_q <= '0;
        v1_q   <= 1'b0;
        d1_q   <= 1'b0;
      end else if (load_en) begin
        sz_q   <= wr_size;
        vpn2_q <= wr_vpn2;
        asid_q <= wr_asid;
        glob_q <= wr_glob;
        pfn0_q <= wr_pfn_even;
        v0_q   <= wr_v_even;
        d0_q   <= wr_d_even;
        pfn1_q <= wr_pfn_odd;
        v1_q   <= wr_v_odd;
        d1_q   <= wr_d_odd;
      end
    end

    // Tag bits under the page-pair offset are ignored for large pages.
    assign care  = {VPN2_W{1'b1}} << {sz_q, 1'b0};
    assign shamt = SH_W'(MIN_SHIFT) + SH_W'({sz_q, 1'b0});
    assign va_sh = lk_va >> shamt;
    assign odd   = va_sh[0];

    assign match_vec[e] = (((vpn2_q ^ lk_tag) & care) == '0) &&
                          (glob_q || (asid_q == lk_asid));
    assign half_pfn[e]  = odd ? pfn1_q : pfn0_q;
    assign half_v[e]    = odd ? v1_q : v0_q;
    assign half_d[e]    = odd ? d1_q : d0_q;
    assign half_sz[e]   = sz_q;

    // R12
    load_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (vpn2_q == $past(wr_vpn2)) && (asid_q == $past(wr_asid)) &&
                  (pfn1_q == $past(wr_pfn_odd)));
  end
endmodule

// File: rtl/ptlb_pick.sv
module ptlb_pick import ptlb_pkg::*; #(
  parameter int N_ENT = 48,
  parameter int PFN_W = 24
) (
  input  logic [N_ENT-1:0]             match_vec,
  input  logic [N_ENT-1:0][PFN_W-1:0]  half_pfn,
  input  logic [N_ENT-1:0]             half_v,
  input  logic [N_ENT-1:0]             half_d,
  input  logic [N_ENT-1:0][SIZE_W-1:0] half_sz,
  output logic                         sel_found,
  output logic [PFN_W-1:0]             sel_pfn,
  output logic                         sel_v,
  output logic                         sel_d,
  output logic [SIZE_W-1:0]            sel_sz
);
  // Scan from the top so the lowest matching index is assigned last.
  always_comb begin
    sel_found = 1'b0;
    sel_pfn   = '0;
    sel_v     = 1'b0;
    sel_d     = 1'b0;
    sel_sz    = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        sel_found = 1'b1;
        sel_pfn   = half_pfn[i];
        sel_v     = half_v[i];
        sel_d     = half_d[i];
        sel_sz    = half_sz[i];
      end
    end
  end
endmodule

// File: rtl/ptlb_resolve.sv
module ptlb_resolve import ptlb_pkg::*; #(
  parameter int VA_W   = 40,
  parameter int VPN2_W = 27,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 24,
  parameter int PA_W   = 36
) (
  input  logic                lk_req,
  input  logic [VA_W-1:0]     lk_va,
  input  logic [ASID_W-1:0]   lk_asid,
  input  logic                lk_write,
  input  logic                sel_found,
  input  logic [PFN_W-1:0]    sel_pfn,
  input  logic                sel_v,
  input  logic                sel_d,
  input  logic [SIZE_W-1:0]   sel_sz,
  output logic                nxt_valid,
  output logic                nxt_hit,
  output logic                nxt_rw,
  output logic [PA_W-1:0]     nxt_pa,
  output fault_code_e         nxt_code,
  output logic                nxt_refill,
  output logic [VPN2_W-1:0]   nxt_ctx_vpn2,
  output logic [ASID_W-1:0]   nxt_ctx_asid
);
  localparam int SH_W = $clog2(PA_W);

  logic [SH_W-1:0] off_bits;
  logic [PA_W-1:0] off_mask;
  logic            fault;

  assign off_bits = SH_W'(MIN_SHIFT) + SH_W'({sel_sz, 1'b0});
  assign off_mask = ~({PA_W{1'b1}} << off_bits);

  always_comb begin
    nxt_valid  = lk_req;
    nxt_hit    = 1'b0;
    nxt_rw     = 1'b0;
    nxt_pa     = '0;
    nxt_code   = CODE_NONE;
    nxt_refill = 1'b0;
    fault      = 1'b0;
    if (lk_req) begin
      if (!sel_found) begin
        fault      = 1'b1;
        nxt_refill = 1'b1;
        nxt_code   = lk_write ? CODE_STORE : CODE_LOAD;
      end else if (!sel_v) begin
        fault    = 1'b1;
        nxt_code = lk_write ? CODE_STORE : CODE_LOAD;
      end else if (lk_write && !sel_d) begin
        fault    = 1'b1;
        nxt_code = CODE_MOD;
      end else begin
        nxt_hit = 1'b1;
        nxt_rw  = sel_d;
        nxt_pa  = {sel_pfn, {MIN_SHIFT{1'b0}}} | (lk_va[PA_W-1:0] & off_mask);
      end
    end
    nxt_ctx_vpn2 = fault ? lk_va[VA_W-1:MIN_SHIFT+1] : '0;
    nxt_ctx_asid = fault ? lk_asid : '0;
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb import ptlb_pkg::*; #(
  parameter int N_ENT  = 48,
  parameter int VA_W   = 40,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 24,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int VPN2_W = VA_W - MIN_SHIFT - 1,
  localparam int PA_W   = PFN_W + MIN_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [2:0]          wr_size,
  input  logic [VPN2_W-1:0]   wr_vpn2,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic                wr_glob,
  input  logic [PFN_W-1:0]    wr_pfn_even,
  input  logic                wr_v_even,
  input  logic                wr_d_even,
  input  logic [PFN_W-1:0]    wr_pfn_odd,
  input  logic                wr_v_odd,
  input  logic                wr_d_odd,
  input  logic                lk_req,
  input  logic [VA_W-1:0]     lk_va,
  input  logic [ASID_W-1:0]   lk_asid,
  input  logic                lk_write,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_rw,
  output logic [PA_W-1:0]     rsp_pa,
  output logic [1:0]          rsp_code,
  output logic                rsp_refill,
  output logic [VPN2_W-1:0]   rsp_ctx_vpn2,
  output logic [ASID_W-1:0]   rsp_ctx_asid
);
  // Reset asserts asynchronously and releases on a clock edge.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [SIZE_W-1:0] size_eff;
  assign size_eff = (wr_size > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : wr_size;

  logic [N_ENT-1:0]             match_vec;
  logic [N_ENT-1:0][PFN_W-1:0]  half_pfn;
  logic [N_ENT-1:0]             half_v, half_d;
  logic [N_ENT-1:0][SIZE_W-1:0] half_sz;

  ptlb_store #(.N_ENT(N_ENT), .IDX_W(IDX_W), .VA_W(VA_W), .VPN2_W(VPN2_W),
               .ASID_W(ASID_W), .PFN_W(PFN_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_size(size_eff), .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_glob(wr_glob),
    .wr_pfn_even(wr_pfn_even), .wr_v_even(wr_v_even), .wr_d_even(wr_d_even),
    .wr_pfn_odd(wr_pfn_odd), .wr_v_odd(wr_v_odd), .wr_d_odd(wr_d_odd),
    .lk_va(lk_va), .lk_asid(lk_asid), .match_vec(match_vec),
    .half_pfn(half_pfn), .half_v(half_v), .half_d(half_d), .half_sz(half_sz));

  logic              sel_found, sel_v, sel_d;
  logic [PFN_W-1:0]  sel_pfn;
  logic [SIZE_W-1:0] sel_sz;

  ptlb_pick #(.N_ENT(N_ENT), .PFN_W(PFN_W)) u_pick (
    .match_vec(match_vec), .half_pfn(half_pfn), .half_v(half_v),
    .half_d(half_d), .half_sz(half_sz), .sel_found(sel_found),
    .sel_pfn(sel_pfn), .sel_v(sel_v), .sel_d(sel_d), .sel_sz(sel_sz));

  logic              nxt_valid, nxt_hit, nxt_rw, nxt_refill;
  logic [PA_W-1:0]   nxt_pa;
  fault_code_e       nxt_code;
  logic [VPN2_W-1:0] nxt_ctx_vpn2;
  logic [ASID_W-1:0] nxt_ctx_asid;

  ptlb_resolve #(.VA_W(VA_W), .VPN2_W(VPN2_W), .ASID_W(ASID_W),
                 .PFN_W(PFN_W), .PA_W(PA_W)) u_resolve (
    .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
    .sel_found(sel_found), .sel_pfn(sel_pfn), .sel_v(sel_v), .sel_d(sel_d),
    .sel_sz(sel_sz), .nxt_valid(nxt_valid), .nxt_hit(nxt_hit), .nxt_rw(nxt_rw),
    .nxt_pa(nxt_pa), .nxt_code(nxt_code), .nxt_refill(nxt_refill),
    .nxt_ctx_vpn2(nxt_ctx_vpn2), .nxt_ctx_asid(nxt_ctx_asid));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_rw       <= 1'b0;
      rsp_pa       <= '0;
      rsp_code     <= 2'd0;
      rsp_refill   <= 1'b0;
      rsp_ctx_vpn2 <= '0;
      rsp_ctx_asid <= '0;
    end else begin
      rsp_valid    <= nxt_valid;
      rsp_hit      <= nxt_hit;
      rsp_rw       <= nxt_rw;
      rsp_pa       <= nxt_pa;
      rsp_code     <= nxt_code;
      rsp_refill   <= nxt_refill;
      rsp_ctx_vpn2 <= nxt_ctx_vpn2;
      rsp_ctx_asid <= nxt_ctx_asid;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_req |=> rsp_valid);
  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_req |=> !rsp_valid && !rsp_hit && (rsp_code == 2'd0));
  // R7
  hit_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_hit |-> rsp_valid && (rsp_code == 2'd0) && !rsp_refill);
  // R9
  modify_on_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_code == 2'd1) |-> $past(lk_write) && !rsp_refill && !rsp_hit);
  // R10
  refill_dir_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_refill |-> rsp_code[1] && (rsp_code[0] == $past(lk_write)) && !rsp_hit);
  // R11
  ctx_clear_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_hit |-> (rsp_ctx_vpn2 == '0) && (rsp_ctx_asid == '0));
endmodule

// File: tb/pair_tlb_tb_top.sv
module pair_tlb_tb_top;
  localparam int N   = 48;
  localparam int VAW = 40;
  localparam int AW  = 8;
  localparam int PW  = 24;
  localparam int VW  = 27;
  localparam int PAW = 36;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic           wr_en;
  logic [5:0]     wr_idx;
  logic [2:0]     wr_size;
  logic [VW-1:0]  wr_vpn2;
  logic [AW-1:0]  wr_asid;
  logic           wr_glob;
  logic [PW-1:0]  wr_pfn_even, wr_pfn_odd;
  logic           wr_v_even, wr_d_even, wr_v_odd, wr_d_odd;
  logic           lk_req, lk_write;
  logic [VAW-1:0] lk_va;
  logic [AW-1:0]  lk_asid;
  logic           rsp_valid, rsp_hit, rsp_rw, rsp_refill;
  logic [PAW-1:0] rsp_pa;
  logic [1:0]     rsp_code;
  logic [VW-1:0]  rsp_ctx_vpn2;
  logic [AW-1:0]  rsp_ctx_asid;

  pair_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_glob(wr_glob),
    .wr_pfn_even(wr_pfn_even), .wr_v_even(wr_v_even), .wr_d_even(wr_d_even),
    .wr_pfn_odd(wr_pfn_odd), .wr_v_odd(wr_v_odd), .wr_d_odd(wr_d_odd),
    .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rw(rsp_rw), .rsp_pa(rsp_pa),
    .rsp_code(rsp_code), .rsp_refill(rsp_refill),
    .rsp_ctx_vpn2(rsp_ctx_vpn2), .rsp_ctx_asid(rsp_ctx_asid));

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  string cur_tag = "R2";

  // Behavioural table
  int          m_sz   [N];
  logic [63:0] m_base [N];
  logic [7:0]  m_asid [N];
  bit          m_g    [N];
  logic [23:0] m_pfn  [N][2];
  bit          m_v    [N][2];
  bit          m_d    [N][2];
  logic [39:0] bases[$];

  logic [76:0] exp_vec;
  string       exp_tag = "R2";

  function automatic logic [76:0] pack_rsp(bit v, bit h, bit rw, logic [1:0] c, bit rf,
                                           logic [35:0] pa, logic [26:0] cv, logic [7:0] ca);
    return {v, h, rw, c, rf, pa, cv, ca};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_sz[i] = 0; m_base[i] = '0; m_asid[i] = '0; m_g[i] = 0;
        for (int h = 0; h < 2; h++) begin m_pfn[i][h] = '0; m_v[i][h] = 0; m_d[i][h] = 0; end
      end
      exp_vec = '0;
      exp_tag = "R1";
    end else begin
      exp_vec = '0;
      exp_tag = "R2";
      if (lk_req) begin
        logic [63:0] va;
        int hit_i;
        int sh;
        int half;
        va = {24'd0, lk_va};
        hit_i = -1;
        sh = 12;
        exp_tag = cur_tag;
        for (int i = 0; i < N && hit_i < 0; i++) begin
          int s;
          s = 12 + 2 * (m_sz[i] > 6 ? 6 : m_sz[i]);
          if (((va >> (s + 1)) == (m_base[i] >> (s + 1))) && (m_g[i] || m_asid[i] == lk_asid)) begin
            hit_i = i;
            sh = s;
          end
        end
        if (hit_i < 0) begin
          exp_vec = pack_rsp(1, 0, 0, lk_write ? 2'd3 : 2'd2, 1, '0, lk_va[39:13], lk_asid);
        end else begin
          half = int'(va[sh]);
          if (!m_v[hit_i][half])
            exp_vec = pack_rsp(1, 0, 0, lk_write ? 2'd3 : 2'd2, 0, '0, lk_va[39:13], lk_asid);
          else if (lk_write && !m_d[hit_i][half])
            exp_vec = pack_rsp(1, 0, 0, 2'd1, 0, '0, lk_va[39:13], lk_asid);
          else begin
            logic [63:0] pa;
            pa = ({40'd0, m_pfn[hit_i][half]} << 12) | (va & ((64'd1 << sh) - 64'd1));
            exp_vec = pack_rsp(1, 1, m_d[hit_i][half], 2'd0, 0, pa[35:0], '0, '0);
          end
        end
      end
      if (wr_en && wr_idx < N) begin
        m_sz[wr_idx]      = int'(wr_size);
        m_base[wr_idx]    = {24'd0, wr_vpn2, 13'd0};
        m_asid[wr_idx]    = wr_asid;
        m_g[wr_idx]       = wr_glob;
        m_pfn[wr_idx][0]  = wr_pfn_even; m_v[wr_idx][0] = wr_v_even; m_d[wr_idx][0] = wr_d_even;
        m_pfn[wr_idx][1]  = wr_pfn_odd;  m_v[wr_idx][1] = wr_v_odd;  m_d[wr_idx][1] = wr_d_odd;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [76:0] act;
      act = pack_rsp(rsp_valid, rsp_hit, rsp_rw, rsp_code, rsp_refill,
                     rsp_pa, rsp_ctx_vpn2, rsp_ctx_asid);
      n_cmp++;
      if (act !== exp_vec) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h (valid,hit,rw,code,refill,pa,ctx_vpn2,ctx_asid)",
                 exp_tag, act, exp_vec);
      end
    end
  end

  task automatic do_write(input int idx, input int sz, input logic [26:0] vpn2,
                          input logic [7:0] asid, input bit g,
                          input logic [23:0] p0, input bit v0, input bit d0,
                          input logic [23:0] p1, input bit v1, input bit d1);
    @(negedge clk);
    wr_en = 1; wr_idx = 6'(idx); wr_size = 3'(sz); wr_vpn2 = vpn2; wr_asid = asid;
    wr_glob = g; wr_pfn_even = p0; wr_v_even = v0; wr_d_even = d0;
    wr_pfn_odd = p1; wr_v_odd = v1; wr_d_odd = d1;
    @(negedge clk);
    wr_en = 0;
    bases.push_back({vpn2, 13'd0});
  endtask

  task automatic do_lookup(input logic [39:0] va, input logic [7:0] asid, input bit w,
                           input string tag);
    @(negedge clk);
    lk_req = 1; lk_va = va; lk_asid = asid; lk_write = w; cur_tag = tag;
    @(negedge clk);
    lk_req = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_idx = '0; wr_size = '0; wr_vpn2 = '0; wr_asid = '0;
    wr_glob = 0; wr_pfn_even = '0; wr_v_even = 0; wr_d_even = 0;
    wr_pfn_odd = '0; wr_v_odd = 0; wr_d_odd = 0;
    lk_req = 0; lk_va = '0; lk_asid = '0; lk_write = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    n_cmp++;
    if ({rsp_valid, rsp_hit, rsp_rw, rsp_code, rsp_refill, rsp_pa, rsp_ctx_vpn2, rsp_ctx_asid} !== '0) begin
      n_bad++;
      $display("FAIL R1: actual %b%b expected 00 in reset", rsp_valid, rsp_hit);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1 / R8: cleared entry 0 matches tag 0, identifier 0, but is invalid
    do_lookup(40'h0_0000_0123, 8'h00, 0, "R1");
    // R10: empty table, read and write refills
    do_lookup(40'h12_3456_7000, 8'h05, 0, "R10");
    do_lookup(40'h12_3456_7000, 8'h05, 1, "R10");

    // 4 KB pair, identifier 0x12, even dirty, odd clean
    do_write(5, 0, 27'h0012345, 8'h12, 0, 24'hA0A0A0, 1, 1, 24'hB0B0B0, 1, 0);
    do_lookup({27'h0012345, 13'h0ABC}, 8'h12, 0, "R6");   // even, offset abc
    do_lookup({27'h0012345, 13'h1FFF}, 8'h12, 0, "R4");   // odd half, read-only
    do_lookup({27'h0012345, 13'h0001}, 8'h12, 1, "R7");   // write even, dirty
    do_lookup({27'h0012345, 13'h1004}, 8'h12, 1, "R9");   // write odd clean
    do_lookup({27'h0012345, 13'h0004}, 8'h13, 0, "R5");   // wrong identifier
    do_lookup({27'h0012346, 13'h0004}, 8'h12, 1, "R11");  // next tag: refill

    // 64 KB pages (code 2), global
    do_write(9, 2, 27'h0400008, 8'h77, 1, 24'h001230, 1, 0, 24'h004560, 1, 1);
    do_lookup({27'h0400008, 13'h0}   | 40'h0_ABCD, 8'h01, 0, "R3");
    do_lookup({27'h0400008, 13'h0}   | 40'h1_ABCD, 8'h99, 1, "R4");
    do_lookup({27'h0400008, 13'h0}   | 40'h1_FFFF, 8'h99, 0, "R5");
    do_lookup({27'h0400008, 13'h0}   | 40'h2_0000, 8'h99, 0, "R3");

    // Invalid odd half, 16 KB pages
    do_write(20, 1, 27'h1000100, 8'h12, 0, 24'h0C0000, 1, 1, 24'h0D0000, 0, 0);
    do_lookup({27'h1000100, 13'h0} | 40'h2123, 8'h12, 0, "R6");
    do_lookup({27'h1000100, 13'h0} | 40'h6123, 8'h12, 0, "R8");
    do_lookup({27'h1000100, 13'h0} | 40'h6123, 8'h12, 1, "R8");

    // Largest size and clamped code 7
    do_write(33, 6, 27'h2800000, 8'h40, 0, 24'h100000, 1, 1, 24'h200000, 1, 1);
    do_write(40, 7, 27'h2C00000, 8'h40, 0, 24'h300000, 1, 1, 24'h400000, 1, 0);
    do_lookup(40'h50_00FE_DCBA, 8'h40, 0, "R3");
    do_lookup(40'h50_01FE_DCBA, 8'h40, 1, "R4");
    do_lookup(40'h58_0123_4567, 8'h40, 0, "R3");
    do_lookup(40'h58_0123_4567 | 40'h100_0000, 8'h40, 1, "R9");

    // Region bits distinguish otherwise equal tags
    do_write(12, 0, {2'b01, 25'h0000777}, 8'h12, 1, 24'h00ABCD, 1, 1, 24'h00DCBA, 1, 1);
    do_lookup({2'b01, 25'h0000777, 13'h0100}, 8'h00, 0, "R3");
    do_lookup({2'b11, 25'h0000777, 13'h0100}, 8'h00, 0, "R3");

    // Overlap: lower index wins
    do_write(31, 0, 27'h0055555, 8'h21, 0, 24'h000031, 1, 1, 24'h000031, 1, 1);
    do_write(30, 0, 27'h0055555, 8'h21, 0, 24'h000030, 1, 1, 24'h000030, 1, 1);
    do_lookup({27'h0055555, 13'h0010}, 8'h21, 0, "R13");

    // Overwrite entry 5 with a different mapping
    do_write(5, 0, 27'h0099999, 8'h12, 0, 24'hEEEEEE, 1, 1, 24'hFFFFFF, 1, 1);
    do_lookup({27'h0012345, 13'h0ABC}, 8'h12, 0, "R12");
    do_lookup({27'h0099999, 13'h0ABC}, 8'h12, 0, "R12");

    // Mixed traffic near loaded mappings
    for (int k = 0; k < 400; k++) begin
      logic [39:0] va;
      logic [7:0]  as;
      va = bases[$urandom_range(bases.size() - 1)] ^ 40'($urandom_range(32'h1FFFFFF));
      case ($urandom_range(2))
        0: as = 8'h12;
        1: as = 8'h40;
        default: as = 8'($urandom);
      endcase
      do_lookup(va, as, 1'($urandom), "R6");
    end

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule